// File: doc/BRIEF.md
# Password Retry Access Gatekeeper

This block decides whether a request against a password-protected memory may go ahead. A requester names an operation class and one of four arrays. The gatekeeper works out which stored 64-bit key that request calls for, if any. When a key is needed, it takes eight presented bytes and compares them against the stored key as a whole. It then reports grant or deny. For a request that needs a key, the verdict is held back until the external write cycle, signalled by `busy`, has finished. The keys have no read path. They are loaded through a provisioning port that stands in for the nonvolatile store.

A failed-attempt counter protects the keys. When it is enabled, the counter is compared with a limit before any key is taken. When the two are equal, a two-bit lockout field decides the outcome: either every request is refused, or only configuration requests still go through. Each wrong key adds one to the counter, which wraps at 8 bits. A correct key clears the counter or leaves it alone, depending on a control bit. Each array has its own policy nibble. The nibble says whether reads or writes need a key and which kinds of write are allowed. One of those write kinds is program-only, where a bit may only go from 1 to 0. Once a write session has been granted, each byte it proposes is checked against that rule.

Top module: `gk_gatekeeper`

## Requirements
- R1: A key is presented as 8 bytes, and the first byte lands in bits 7:0. The request is granted only when all 64 bits equal the stored key, so a single differing bit gives a deny.
- R2: Lockout is in force when the counter enable is 1 and the counter equals the limit. With lockout field 2'b10, every request is refused and `all_locked`=1. With any other value of the field, only op 2 (configuration) proceeds and `cfg_only`=1.
- R3: With the counter enabled, a wrong key raises the counter by exactly one.
- R4: With the counter enabled, a correct key clears the counter when the clear bit is 1 and leaves it unchanged when the clear bit is 0.
- R5: The counter wraps from 255 to 0. A counter that starts above the limit therefore allows attempts until it wraps round and reaches the limit.
- R6: With the counter enable at 0, the counter is never updated and lockout never occurs.
- R7: Array nibble bit 0 makes a read (op 0) need the read key. Bit 1 makes a write (op 1) need the write key. A request that needs no key gets `res_valid` with a grant in the cycle after `req_start`.
- R8: Nibble bits 3:2 set what an array allows: 00 allows everything, 01 refuses writes, 10 allows program-only writes, and 11 refuses reads and writes. Op codes 5 to 7 are always refused.
- R9: In a granted write session on a program-only array, a byte that would turn any 0 into a 1 gives `chk_ok`=0 and ends the session. Clearing bits only gives `chk_ok`=1.
- R10: Op 2 uses the configuration key and ignores the array nibble. Op 3 (change read key) needs the read key, and op 4 (change write key) needs the write key, not the configuration key.
- R11: For a request that needs a key, `res_valid` stays low while `busy` is high. A wrong key gives a deny after `busy` falls.
- R12: When a provisioning write to the counter (select 4) lands in the same cycle as the attempt's counter update, the update wins.

Provisioning selects: 0 is the read key, 1 the write key, 2 the configuration key, 3 the limit, and 4 the counter. Select 5 is the control field: bits 1:0 are the lockout field, bit 2 the enable and bit 3 the clear bit. Select 6 is the array map, with the nibble for array a in bits 4a+3:4a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prov_we | input | 1 | Provisioning write strobe |
| prov_sel | input | 3 | Provisioning target select |
| prov_data | input | 64 | Provisioning data |
| req_start | input | 1 | Start a request (taken only when idle) |
| req_op | input | 3 | Operation class |
| req_arr | input | 2 | Target array |
| pw_valid | input | 1 | Presented key byte valid |
| pw_byte | input | 8 | Presented key byte |
| busy | input | 1 | External write cycle in progress |
| stop | input | 1 | End the session or abort it |
| chk_valid | input | 1 | Proposed write byte valid |
| chk_old | input | 8 | Current stored byte |
| chk_new | input | 8 | Proposed new byte |
| res_valid | output | 1 | Verdict strobe |
| res_grant | output | 1 | Verdict: 1 grant, 0 deny |
| chk_ack | output | 1 | Write-check strobe |
| chk_ok | output | 1 | Write byte accepted |
| cfg_only | output | 1 | Locked; configuration requests only |
| all_locked | output | 1 | Locked; every request refused |

## Verification
The counter update of an attempt and a provisioning write to the counter can fall in the same clock edge. The bench provokes this by raising the provisioning strobe in the cycle that follows the eighth key byte, with a wrong key and the counter one below the limit. It judges the outcome from the lock outputs: the counter must reach the limit rather than take the written value. A second overlap occurs between the write-cycle wait and the verdict. Random `busy` lengths check that no verdict appears while `busy` is high.

// File: rtl/gk_pkg.sv
package gk_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_CFG     = 3'd2,
    OP_SET_RPW = 3'd3,
    OP_SET_WPW = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    NEED_NONE = 2'd0,
    NEED_RD   = 2'd1,
    NEED_WR   = 2'd2,
    NEED_CFG  = 2'd3
  } need_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_CHECK   = 3'd2,
    ST_WAIT    = 3'd3,
    ST_GRANT   = 3'd4
  } state_e;

  localparam logic [2:0] SEL_PW_RD  = 3'd0;
  localparam logic [2:0] SEL_PW_WR  = 3'd1;
  localparam logic [2:0] SEL_PW_CFG = 3'd2;
  localparam logic [2:0] SEL_LIMIT  = 3'd3;
  localparam logic [2:0] SEL_COUNT  = 3'd4;
  localparam logic [2:0] SEL_CTRL   = 3'd5;
  localparam logic [2:0] SEL_AMAP   = 3'd6;

  localparam logic [1:0] LOCK_ALL   = 2'b10;
  localparam logic [1:0] FN_RDONLY  = 2'b01;
  localparam logic [1:0] FN_PROG    = 2'b10;
  localparam logic [1:0] FN_CLOSED  = 2'b11;
endpackage

// File: rtl/gk_pw_shift.sv
module gk_pw_shift #(
  parameter int BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 vld,
  input  logic [7:0]           byte_in,
  output logic [BYTES*8-1:0]   value,
  output logic                 last
);
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTES - 1);

  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [BYTES*8-1:0] val_d;
  logic               en;

  always_comb begin
    en    = clr | vld;
    idx_d = clr ? '0 : idx_q + 1'b1;
    val_d = clr ? '0 : {byte_in, value[BYTES*8-1:8]};
  end

  assign last = vld & (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      value <= '0;
    end else if (en) begin
      idx_q <= idx_d;
      value <= val_d;
    end
  end
endmodule

// File: rtl/gk_retry.sv
module gk_retry #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_we,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             enable,
  input  logic             upd,
  input  logic             match,
  input  logic             clr_on_ok,
  output logic             at_limit
);
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q;
  logic             cnt_en;
  logic             att;

  always_comb begin
    att    = enable & upd;
    cnt_en = att | cnt_we;
    if (att)
      cnt_d = match ? (clr_on_ok ? '0 : cnt_q) : cnt_q + 1'b1;
    else
      cnt_d = wdata;
  end

  assign at_limit = (cnt_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (lim_we) lim_q <= wdata;
    end
  end

  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && upd && !match) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R3
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && upd && match && clr_on_ok) |=> (cnt_q == '0)); // R4
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !cnt_we) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/gk_policy.sv
module gk_policy
  import gk_pkg::*;
(
  input  logic [2:0] op,
  input  logic [3:0] nib,
  input  logic       locked,
  input  logic [1:0] lock_mode,
  output logic       deny,
  output need_e      need
);
  logic rd_req, wr_req;
  logic [1:0] fn;

  always_comb begin
    rd_req = nib[0];
    wr_req = nib[1];
    fn     = nib[3:2];
    deny   = 1'b0;
    need   = NEED_NONE;
    if (locked && (lock_mode == LOCK_ALL || op != OP_CFG)) begin
      deny = 1'b1;
    end else begin
      case (op)
        OP_READ:    begin
          deny = (fn == FN_CLOSED);
          need = rd_req ? NEED_RD : NEED_NONE;
        end
        OP_WRITE:   begin
          deny = (fn == FN_RDONLY) || (fn == FN_CLOSED);
          need = wr_req ? NEED_WR : NEED_NONE;
        end
        OP_CFG:     need = NEED_CFG;
        OP_SET_RPW: need = NEED_RD;
        OP_SET_WPW: need = NEED_WR;
        default:    deny = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/gk_gatekeeper.sv
module gk_gatekeeper
  import gk_pkg::*;
#(
  parameter int PW_BYTES = 8,
  parameter int NUM_ARR  = 4,
  parameter int CNT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prov_we,
  input  logic [2:0]                  prov_sel,
  input  logic [PW_BYTES*8-1:0]       prov_data,
  input  logic                        req_start,
  input  logic [2:0]                  req_op,
  input  logic [$clog2(NUM_ARR)-1:0]  req_arr,
  input  logic                        pw_valid,
  input  logic [7:0]                  pw_byte,
  input  logic                        busy,
  input  logic                        stop,
  input  logic                        chk_valid,
  input  logic [7:0]                  chk_old,
  input  logic [7:0]                  chk_new,
  output logic                        res_valid,
  output logic                        res_grant,
  output logic                        chk_ack,
  output logic                        chk_ok,
  output logic                        cfg_only,
  output logic                        all_locked
);
  localparam int PW_W  = PW_BYTES * 8;
  localparam int ARR_W = $clog2(NUM_ARR);
  localparam int MAP_W = NUM_ARR * 4;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  // provisioned state
  logic [PW_W-1:0]  key_rd, key_wr, key_cfg;
  logic [MAP_W-1:0] amap;
  logic [1:0]       lock_mode;
  logic             rce, rcr;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      key_rd <= '0; key_wr <= '0; key_cfg <= '0;
      amap <= '0; lock_mode <= '0; rce <= 1'b0; rcr <= 1'b0;
    end else if (prov_we) begin
      if (prov_sel == SEL_PW_RD)  key_rd  <= prov_data;
      if (prov_sel == SEL_PW_WR)  key_wr  <= prov_data;
      if (prov_sel == SEL_PW_CFG) key_cfg <= prov_data;
      if (prov_sel == SEL_AMAP)   amap    <= prov_data[MAP_W-1:0];
      if (prov_sel == SEL_CTRL) begin
        lock_mode <= prov_data[1:0];
        rce       <= prov_data[2];
        rcr       <= prov_data[3];
      end
    end
  end

  // session state
  state_e           st_q, st_d;
  logic [2:0]       op_q;
  logic [ARR_W-1:0] arr_q;
  need_e            need_q, pol_need;
  logic             match_q, pol_deny;
  logic             rv_d, rg_d, ack_d, ok_d, cap, clr, upd;
  logic             at_limit, locked, last, match, prog, viol;
  logic [PW_W-1:0]  presented, expect_key;
  logic [3:0]       req_nib, ses_nib;

  assign locked     = rce & at_limit;
  assign cfg_only   = locked & (lock_mode != LOCK_ALL);
  assign all_locked = locked & (lock_mode == LOCK_ALL);
  assign req_nib    = amap[{req_arr, 2'b00} +: 4];
  assign ses_nib    = amap[{arr_q, 2'b00} +: 4];

  gk_policy u_pol (
    .op(req_op), .nib(req_nib), .locked(locked), .lock_mode(lock_mode),
    .deny(pol_deny), .need(pol_need)
  );

  gk_pw_shift #(.BYTES(PW_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_s), .clr(clr),
    .vld(pw_valid && st_q == ST_COLLECT), .byte_in(pw_byte),
    .value(presented), .last(last)
  );

  gk_retry #(.CNT_W(CNT_W)) u_retry (
    .clk(clk), .rst_n(rst_s),
    .lim_we(prov_we && prov_sel == SEL_LIMIT),
    .cnt_we(prov_we && prov_sel == SEL_COUNT),
    .wdata(prov_data[CNT_W-1:0]), .enable(rce), .upd(upd),
    .match(match), .clr_on_ok(rcr), .at_limit(at_limit)
  );

  always_comb begin
    case (need_q)
      NEED_RD:  expect_key = key_rd;
      NEED_WR:  expect_key = key_wr;
      default:  expect_key = key_cfg;
    endcase
  end
  assign match = (presented == expect_key);
  assign prog  = (op_q == OP_WRITE) && (ses_nib[3:2] == FN_PROG);
  assign viol  = prog && ((chk_new & ~chk_old) != 8'h00);

  // next state
  always_comb begin
    st_d = st_q; rv_d = 1'b0; rg_d = 1'b0; ack_d = 1'b0; ok_d = 1'b0;
    cap = 1'b0; clr = 1'b0; upd = 1'b0;
    case (st_q)
      ST_IDLE: if (req_start) begin
        cap = 1'b1;
        if (pol_deny) begin
          rv_d = 1'b1;
        end else if (pol_need == NEED_NONE) begin
          rv_d = 1'b1; rg_d = 1'b1; st_d = ST_GRANT;
        end else begin
          clr = 1'b1; st_d = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (stop)      st_d = ST_IDLE;
        else if (last) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        upd  = 1'b1;
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (stop) st_d = ST_IDLE;
        else if (!busy) begin
          rv_d = 1'b1; rg_d = match_q;
          st_d = match_q ? ST_GRANT : ST_IDLE;
        end
      end
      ST_GRANT: begin
        if (stop) st_d = ST_IDLE;
        else if (chk_valid) begin
          ack_d = 1'b1;
          ok_d  = (op_q == OP_WRITE || op_q == OP_CFG) && !viol;
          if (!ok_d) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; op_q <= '0; arr_q <= '0; need_q <= NEED_NONE;
      match_q <= 1'b0; res_valid <= 1'b0; res_grant <= 1'b0;
      chk_ack <= 1'b0; chk_ok <= 1'b0;
    end else begin
      st_q      <= st_d;
      res_valid <= rv_d;
      res_grant <= rg_d;
      chk_ack   <= ack_d;
      chk_ok    <= ok_d;
      if (cap) begin
        op_q <= req_op; arr_q <= req_arr; need_q <= pol_need;
      end
      if (upd) match_q <= match;
    end
  end

  AST_LOCK_DENY: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_IDLE && req_start && all_locked) |=> (res_valid && !res_grant)); // R2
  AST_NO_RES_BUSY: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_WAIT && busy) |=> !res_valid); // R11
  AST_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_GRANT && !stop && chk_valid && viol) |=> (chk_ack && !chk_ok && st_q == ST_IDLE)); // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_s)
    !(res_valid && chk_ack)); // R7
endmodule

// File: tb/sim_gk_gatekeeper.sv
module sim_gk_gatekeeper;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prov_we = 0; logic [2:0] prov_sel = 0; logic [63:0] prov_data = 0;
  logic req_start = 0; logic [2:0] req_op = 0; logic [1:0] req_arr = 0;
  logic pw_valid = 0; logic [7:0] pw_byte = 0; logic busy = 0, stop = 0;
  logic chk_valid = 0; logic [7:0] chk_old = 0, chk_new = 0;
  logic res_valid, res_grant, chk_ack, chk_ok, cfg_only, all_locked;

  int n_run = 0, n_fail = 0;

  // model state
  logic [63:0] m_rd = 0, m_wr = 0, m_cfg = 0;
  logic [15:0] m_amap = 0;
  logic [7:0]  m_cnt = 0, m_lim = 0;
  logic [1:0]  m_ua = 0;
  logic        m_rce = 0, m_rcr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gk_gatekeeper u0 (
    .clk(clk), .rst_n(rst_n), .prov_we(prov_we), .prov_sel(prov_sel),
    .prov_data(prov_data), .req_start(req_start), .req_op(req_op),
    .req_arr(req_arr), .pw_valid(pw_valid), .pw_byte(pw_byte), .busy(busy),
    .stop(stop), .chk_valid(chk_valid), .chk_old(chk_old), .chk_new(chk_new),
    .res_valid(res_valid), .res_grant(res_grant), .chk_ack(chk_ack),
    .chk_ok(chk_ok), .cfg_only(cfg_only), .all_locked(all_locked)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic prov(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk); prov_we = 1; prov_sel = sel; prov_data = d;
    @(negedge clk); prov_we = 0;
  endtask

  task automatic set_ctrl(input logic [1:0] ua, input logic rce, input logic rcr);
    m_ua = ua; m_rce = rce; m_rcr = rcr;
    prov(3'd5, {60'd0, rcr, rce, ua});
  endtask

  task automatic set_cnt(input logic [7:0] lim, input logic [7:0] cnt);
    m_lim = lim; m_cnt = cnt;
    prov(3'd3, {56'd0, lim}); prov(3'd4, {56'd0, cnt});
  endtask

  task automatic set_map(input logic [15:0] m);
    m_amap = m; prov(3'd6, {48'd0, m});
  endtask

  task automatic end_sess;
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  // expected policy: {deny, need}; need 0 none, 1 read key, 2 write key, 3 config key
  function automatic logic [2:0] exp_pol(input logic [2:0] op, input logic [1:0] arr);
    logic [3:0] nb;
    logic lk;
    nb = m_amap[arr*4 +: 4];
    lk = m_rce && (m_cnt == m_lim);
    if (op > 3'd4) return 3'b100;
    if (lk && (m_ua == 2'b10 || op != 3'd2)) return 3'b100;
    case (op)
      3'd0: return (nb[3:2] == 2'b11) ? 3'b100 : {1'b0, (nb[0] ? 2'd1 : 2'd0)};
      3'd1: return (nb[3:2] == 2'b01 || nb[3:2] == 2'b11) ? 3'b100 : {1'b0, (nb[1] ? 2'd2 : 2'd0)};
      3'd2: return 3'b011;
      3'd3: return 3'b001;
      default: return 3'b010;
    endcase
  endfunction

  function automatic logic [63:0] key_of(input logic [1:0] nd);
    case (nd)
      2'd1: return m_rd;
      2'd2: return m_wr;
      default: return m_cfg;
    endcase
  endfunction

  // returns the design's verdict through gr
  task automatic run_req(input string tag, input logic [2:0] op, input logic [1:0] arr,
                         input logic [63:0] pw, input int bcyc, input bit race,
                         input logic [7:0] race_val, input bit keep, output logic gr);
    logic [2:0] e;
    logic mt;
    e = exp_pol(op, arr);
    @(negedge clk); req_start = 1; req_op = op; req_arr = arr; busy = 1;
    @(negedge clk); req_start = 0;
    if (e[2] || e[1:0] == 2'd0) begin
      busy = 0;
      check({tag, " immediate verdict"}, {63'd0, res_valid}, 64'd1);
      check({tag, " grant"}, {63'd0, res_grant}, {63'd0, ~e[2]});
      gr = res_grant;
      if (res_grant && !keep) end_sess;
    end else begin
      check({tag, " no early verdict"}, {63'd0, res_valid}, 64'd0);
      for (int i = 0; i < 8; i++) begin
        pw_valid = 1; pw_byte = pw[i*8 +: 8];
        @(negedge clk);
      end
      pw_valid = 0;
      if (race) begin prov_we = 1; prov_sel = 3'd4; prov_data = {56'd0, race_val}; end
      @(negedge clk);
      prov_we = 0;
      for (int k = 0; k < bcyc; k++) begin
        @(negedge clk);
        check({tag, " R11 held while busy"}, {63'd0, res_valid}, 64'd0);
      end
      busy = 0;
      @(negedge clk);
      mt = (pw == key_of(e[1:0]));
      check({tag, " verdict after busy"}, {63'd0, res_valid}, 64'd1);
      check({tag, " key verdict"}, {63'd0, res_grant}, {63'd0, mt});
      gr = res_grant;
      if (m_rce) begin
        if (!mt) m_cnt = m_cnt + 8'd1;
        else if (m_rcr) m_cnt = 8'd0;
      end else if (race) m_cnt = race_val;
      if (res_grant && !keep) end_sess;
    end
    check({tag, " cfg_only"}, {63'd0, cfg_only},
          {63'd0, m_rce && m_cnt == m_lim && m_ua != 2'b10});
    check({tag, " all_locked"}, {63'd0, all_locked},
          {63'd0, m_rce && m_cnt == m_lim && m_ua == 2'b10});
  endtask

  task automatic wchk(input string tag, input logic [7:0] o, input logic [7:0] n,
                      input logic eack, input logic eok);
    @(negedge clk); chk_valid = 1; chk_old = o; chk_new = n;
    @(negedge clk); chk_valid = 0;
    check({tag, " ack"}, {63'd0, chk_ack}, {63'd0, eack});
    check({tag, " ok"}, {63'd0, chk_ok}, {63'd0, eok});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++; n_run++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic g;
    logic [2:0] e;
    logic [63:0] p;
    int sd;
    sd = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("reset res_valid", {63'd0, res_valid}, 64'd0);
    check("reset locks", {62'd0, cfg_only, all_locked}, 64'd0);
    check("reset chk_ack", {63'd0, chk_ack}, 64'd0);

    m_rd = 64'h0123_4567_89AB_CDEF; m_wr = 64'hFEDC_BA98_7654_3210;
    m_cfg = 64'hA5A5_5A5A_C3C3_3C3C;
    prov(3'd0, m_rd); prov(3'd1, m_wr); prov(3'd2, m_cfg);

    // R7: free array grants at once
    set_map(16'h0000);
    run_req("R7 free read", 3'd0, 2'd0, 64'd0, 0, 0, 0, 0, g);
    // R1: full 64-bit compare
    set_map(16'h0010);
    run_req("R1 good key", 3'd0, 2'd1, m_rd, 2, 0, 0, 0, g);
    run_req("R1 top byte off", 3'd0, 2'd1, m_rd ^ 64'h0100_0000_0000_0000, 1, 0, 0, 0, g);
    run_req("R1 low bit off", 3'd0, 2'd1, m_rd ^ 64'h1, 0, 0, 0, 0, g);
    // R11: long busy
    run_req("R11 long busy", 3'd0, 2'd1, m_rd ^ 64'h8, 12, 0, 0, 0, g);
    // R3 / R2 lockout configuration-only
    set_ctrl(2'b00, 1, 1); set_cnt(8'd2, 8'd0);
    run_req("R3 wrong 1", 3'd0, 2'd1, 64'd5, 0, 0, 0, 0, g);
    run_req("R3 wrong 2", 3'd0, 2'd1, 64'd5, 0, 0, 0, 0, g);
    run_req("R2 read refused", 3'd0, 2'd0, 64'd0, 0, 0, 0, 0, g);
    run_req("R2 cfg allowed R4", 3'd2, 2'd0, m_cfg, 1, 0, 0, 0, g);
    // R2 lock-all
    set_ctrl(2'b10, 1, 1); set_cnt(8'd1, 8'd0);
    run_req("R3 wrong", 3'd2, 2'd0, 64'd7, 0, 0, 0, 0, g);
    run_req("R2 cfg refused", 3'd2, 2'd0, m_cfg, 0, 0, 0, 0, g);
    // R4 clear bit 0
    set_ctrl(2'b00, 1, 0); set_cnt(8'd3, 8'd0);
    run_req("R4 wrong", 3'd0, 2'd1, 64'd1, 0, 0, 0, 0, g);
    run_req("R4 good keeps", 3'd0, 2'd1, m_rd, 0, 0, 0, 0, g);
    run_req("R4 wrong", 3'd0, 2'd1, 64'd1, 0, 0, 0, 0, g);
    run_req("R4 wrong lock", 3'd0, 2'd1, 64'd1, 0, 0, 0, 0, g);
    // R5 wrap
    set_ctrl(2'b00, 1, 1); set_cnt(8'd2, 8'd250);
    for (int i = 0; i < 8; i++) run_req("R5 wrap", 3'd0, 2'd1, 64'd9, 0, 0, 0, 0, g);
    check("R5 locked after wrap", {63'd0, cfg_only}, 64'd1);
    // R6 disabled counter
    set_ctrl(2'b10, 0, 0); set_cnt(8'd4, 8'd4);
    check("R6 no lock when disabled", {62'd0, cfg_only, all_locked}, 64'd0);
    run_req("R6 wrong", 3'd0, 2'd1, 64'd3, 0, 0, 0, 0, g);
    run_req("R6 wrong", 3'd0, 2'd1, 64'd3, 0, 0, 0, 0, g);
    set_ctrl(2'b10, 1, 0);
    check("R6 counter untouched", {63'd0, all_locked}, 64'd1);
    set_ctrl(2'b00, 0, 0);
    // R8 function bits: arr0 read-only, arr1 closed, arr2 program-only
    set_map(16'h08C4);
    run_req("R8 ro write", 3'd1, 2'd0, 64'd0, 0, 0, 0, 0, g);
    run_req("R8 ro read", 3'd0, 2'd0, 64'd0, 0, 0, 0, 0, g);
    run_req("R8 closed read", 3'd0, 2'd1, 64'd0, 0, 0, 0, 0, g);
    run_req("R8 closed write", 3'd1, 2'd1, 64'd0, 0, 0, 0, 0, g);
    run_req("R8 reserved op", 3'd6, 2'd3, 64'd0, 0, 0, 0, 0, g);
    // R10 overrides and key changes
    run_req("R10 cfg on closed", 3'd2, 2'd1, m_cfg, 0, 0, 0, 0, g);
    run_req("R10 set rd with rd key", 3'd3, 2'd0, m_rd, 0, 0, 0, 0, g);
    run_req("R10 set rd with cfg key", 3'd3, 2'd0, m_cfg, 0, 0, 0, 0, g);
    run_req("R10 set wr with wr key", 3'd4, 2'd0, m_wr, 0, 0, 0, 0, g);
    // R9 program-only
    run_req("R9 open", 3'd1, 2'd2, 64'd0, 0, 0, 0, 1, g);
    wchk("R9 clear bits", 8'hF0, 8'h70, 1, 1);
    wchk("R9 set bit", 8'h0F, 8'h1F, 1, 0);
    wchk("R9 session over", 8'h00, 8'h00, 0, 0);
    run_req("R9 cfg open", 3'd2, 2'd2, m_cfg, 0, 0, 0, 1, g);
    wchk("R9 cfg override", 8'h00, 8'hFF, 1, 1);
    end_sess;
    // R12 race
    set_map(16'h0001); set_ctrl(2'b00, 1, 1); set_cnt(8'd4, 8'd3);
    run_req("R12 race", 3'd0, 2'd0, 64'd2, 1, 1, 8'd0, 0, g);
    check("R12 update wins", {63'd0, cfg_only}, 64'd1);

    // random phase
    for (int it = 0; it < 200; it++) begin
      if ($urandom % 8 == 0) begin
        set_map(16'($urandom));
        set_ctrl(2'($urandom), 1'($urandom), 1'($urandom));
        set_cnt(8'($urandom % 6), 8'($urandom % 6));
      end
      req_op = 3'($urandom % 6); req_arr = 2'($urandom);
      e = exp_pol(req_op, req_arr);
      p = key_of(e[1:0]);
      if ($urandom % 2) p = p ^ (64'd1 << ($urandom % 64));
      run_req("R7 R8 random", req_op, req_arr, p, int'($urandom % 4),
              ($urandom % 10 == 0), 8'($urandom), 0, g);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule